// File: doc/BRIEF.md
# Configuration Startup and Reset Controller

This block is the control state machine that takes a programmable device from power-up, through loading of its configuration, into normal operation, and that handles power-down, reconfiguration and readback requests afterwards. It waits for an internal power-on timeout and for the user reset pin to be released. It then samples the three mode lines once and asks the external data loader to start, passing it the latched mode. When the loader reports that it is finished, the controller brings the device alive in a fixed order: output buffers first, then internal activity, with DONE placed one cycle before or one cycle after activation.

Once the device is operating, the user reset pin no longer restarts anything. It only clears the storage elements, and it does so asynchronously. A falling edge on the done/program pin starts a full reconfiguration. A rising edge on mode line 0 requests a readback. A low on the power-down pin darkens the device, and its release replays the activation order. All pins except the loader strobe pass through two-flop synchronizers. The block has no streaming data path, so every port is a plain control level or a one-cycle pulse.

Top module: `cfgseq_ctrl`

## Requirements
- R1: While `por_n` is low, `cfg_start`, `obuf_en`, `core_en`, `done_drv` and `rb_start` are 0, `store_rst` is 1 and `cfg_mode` is 0.
- R2: With `usr_rst_n` high, `cfg_start` first goes high exactly POR_CYCLES+1 clock cycles after `por_n` is released, for one cycle only.
- R3: While `usr_rst_n` is held low after the timeout, no configuration starts. `cfg_start` pulses on the third rising clock edge after `usr_rst_n` goes high.
- R4: `cfg_mode` holds the value of `mode_pins` (bit 0 = mode line 0) captured when `cfg_start` pulses, and it keeps that value until the next pulse.
- R5: A low on `usr_rst_n` while waiting for the loader returns the block to initialization. A `load_done` seen there is ignored, and configuration restarts with a fresh mode sample on release.
- R6: A `load_done` strobe while configuring raises `obuf_en` one cycle later and `core_en` two cycles later, and the block is operating three cycles later. `done_drv` rises one cycle before `core_en` when `done_early`=1, and one cycle after it otherwise.
- R7: While operating, a low on `usr_rst_n` raises `store_rst` without waiting for a clock. `obuf_en`, `core_en` and `done_drv` stay high, and no reconfiguration starts.
- R8: While operating, `pwrdn_n` low clears `obuf_en`, `core_en` and `done_drv` and sets `store_rst` three cycles later. Its release replays the R6 order, starting three cycles after release.
- R9: While operating, a falling edge on `prog_n` clears all activity three cycles later, and `cfg_start` pulses four cycles later.
- R10: While operating, a rising edge on mode line 0 gives a one-cycle `rb_start` pulse three cycles later. A falling edge gives none.
- R11: Edges on `prog_n` or mode line 0 that occur outside the operating state are ignored. A level raised earlier does not trigger once operation begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| por_n | input | 1 | Power-on reset of the controller, active low, asynchronous |
| usr_rst_n | input | 1 | User reset pin, active low |
| pwrdn_n | input | 1 | Power-down pin, active low |
| mode_pins | input | 3 | Mode lines; bit 0 doubles as readback trigger |
| prog_n | input | 1 | Done/program pin level; falling edge requests reconfiguration |
| load_done | input | 1 | One-cycle strobe from the data loader, synchronous |
| done_early | input | 1 | 1: DONE one cycle before activation; 0: one cycle after |
| cfg_start | output | 1 | One-cycle request to the loader to begin |
| cfg_mode | output | 3 | Mode latched at the start request |
| obuf_en | output | 1 | Output buffer enable (0 = high impedance) |
| core_en | output | 1 | Internal activity enable |
| done_drv | output | 1 | DONE drive |
| store_rst | output | 1 | Storage-element reset |
| rb_start | output | 1 | One-cycle readback start pulse |

## Verification
The bench targets the triple meaning of the user reset. A design that restarted configuration on a reset during operation would pulse `cfg_start` again, and one that clocked the storage reset would miss the check made one nanosecond after the pin falls. It checks that edges arriving before operation are dropped: a design that tracked edges only inside the operating state would fire a stale readback or reconfiguration on entry. It measures the exact power-on and startup latencies under both DONE options and through a power-down resume, so an off-by-one timeout or a swapped DONE/activation order shows as a wrong output vector.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [2:0] {
    ST_POR     = 3'd0,
    ST_INIT    = 3'd1,
    ST_CONFIG  = 3'd2,
    ST_STARTUP = 3'd3,
    ST_OPER    = 3'd4,
    ST_PDOWN   = 3'd5
  } seq_state_t;

  localparam int MODE_W = 3;
endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cfgseq_edge.sv
module cfgseq_edge #(
  parameter bit FALLING = 1'b0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic edge_o
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev & ~lvl;
    end else begin : g_rise
      assign edge_o = ~prev & lvl;
    end
  endgenerate
endmodule

// File: rtl/cfgseq_por_timer.sv
module cfgseq_por_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired
);
  localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [W-1:0] LIM = W'(CYCLES - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired); // R2
endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_done,
  input  logic              usr_rel,
  input  logic              pwr_on,
  input  logic              prog_fall,
  input  logic              trig_rise,
  input  logic [MODE_W-1:0] mode_s,
  input  logic              load_done,
  input  logic              done_early,
  output logic              cfg_start,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              obuf_en,
  output logic              core_en,
  output logic              done_drv,
  output logic              rb_start,
  output logic              in_oper
);
  seq_state_t state, nxt;
  logic       phase, phase_n;
  logic       start_n, rb_n;

  always_comb begin
    nxt     = state;
    phase_n = phase;
    start_n = 1'b0;
    rb_n    = 1'b0;
    case (state)
      ST_POR: begin
        if (tmo_done) nxt = ST_INIT;
      end
      ST_INIT: begin
        if (usr_rel) begin
          nxt     = ST_CONFIG;
          start_n = 1'b1;
        end
      end
      ST_CONFIG: begin
        if (!usr_rel) begin
          nxt = ST_INIT;
        end else if (load_done) begin
          nxt     = ST_STARTUP;
          phase_n = 1'b0;
        end
      end
      ST_STARTUP: begin
        if (phase) nxt = ST_OPER;
        else       phase_n = 1'b1;
      end
      ST_OPER: begin
        if (prog_fall)      nxt = ST_INIT;
        else if (!pwr_on)   nxt = ST_PDOWN;
        else if (trig_rise) rb_n = 1'b1;
      end
      ST_PDOWN: begin
        if (pwr_on) begin
          nxt     = ST_STARTUP;
          phase_n = 1'b0;
        end
      end
      default: nxt = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_POR;
      phase     <= 1'b0;
      cfg_start <= 1'b0;
      cfg_mode  <= '0;
      rb_start  <= 1'b0;
    end else begin
      state     <= nxt;
      phase     <= phase_n;
      cfg_start <= start_n;
      rb_start  <= rb_n;
      if (start_n) cfg_mode <= mode_s;
    end
  end

  assign in_oper  = (state == ST_OPER);
  assign obuf_en  = (state == ST_STARTUP) || in_oper;
  assign core_en  = ((state == ST_STARTUP) && phase) || in_oper;
  assign done_drv = in_oper || ((state == ST_STARTUP) && done_early);

  AST_CFG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> !cfg_start); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_start |-> $stable(cfg_mode)); // R4
  AST_RB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_start |=> !rb_start); // R10
  AST_RB_FROM_OPER: assert property (@(posedge clk) disable iff (!rst_n)
    rb_start |-> $past(in_oper)); // R11
  AST_CORE_AFTER_OBUF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> $past(obuf_en)); // R6
  AST_DONE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> (done_drv == done_early)); // R6
  AST_PDOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_oper && !pwr_on && !prog_fall) |=> !obuf_en); // R8
endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
#(
  parameter int POR_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              usr_rst_n,
  input  logic              pwrdn_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              prog_n,
  input  logic              load_done,
  input  logic              done_early,
  output logic              cfg_start,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              obuf_en,
  output logic              core_en,
  output logic              done_drv,
  output logic              store_rst,
  output logic              rb_start
);
  localparam int SW = MODE_W + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, {MODE_W{1'b0}}};

  logic [SW-1:0]     sync_q;
  logic              usr_rel, pwr_on, prog_s;
  logic [MODE_W-1:0] mode_s;
  logic              tmo_done, prog_fall, trig_rise, in_oper;

  cfgseq_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(por_n),
    .d    ({usr_rst_n, pwrdn_n, prog_n, mode_pins}),
    .q    (sync_q)
  );

  assign {usr_rel, pwr_on, prog_s, mode_s} = sync_q;

  cfgseq_por_timer #(.CYCLES(POR_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (por_n),
    .expired(tmo_done)
  );

  cfgseq_edge #(.FALLING(1'b1), .RST_VAL(1'b1)) u_prog_edge (
    .clk   (clk),
    .rst_n (por_n),
    .lvl   (prog_s),
    .edge_o(prog_fall)
  );

  cfgseq_edge #(.FALLING(1'b0), .RST_VAL(1'b0)) u_trig_edge (
    .clk   (clk),
    .rst_n (por_n),
    .lvl   (mode_s[0]),
    .edge_o(trig_rise)
  );

  cfgseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (por_n),
    .tmo_done  (tmo_done),
    .usr_rel   (usr_rel),
    .pwr_on    (pwr_on),
    .prog_fall (prog_fall),
    .trig_rise (trig_rise),
    .mode_s    (mode_s),
    .load_done (load_done),
    .done_early(done_early),
    .cfg_start (cfg_start),
    .cfg_mode  (cfg_mode),
    .obuf_en   (obuf_en),
    .core_en   (core_en),
    .done_drv  (done_drv),
    .rb_start  (rb_start),
    .in_oper   (in_oper)
  );

  // Storage reset: held while inactive, and taken straight from the pin while operating.
  assign store_rst = ~core_en | (in_oper & ~usr_rst_n);

  AST_NO_RECFG_ON_USR_RST: assert property (@(posedge clk) disable iff (!por_n)
    (in_oper && !usr_rel && prog_s) |=> !cfg_start); // R7
  AST_SRST_IN_OPER: assert property (@(posedge clk) disable iff (!por_n)
    (in_oper && !usr_rst_n) |-> (store_rst && core_en)); // R7
endmodule

// File: tb/tb_cfgseq_ctrl.sv
module tb_cfgseq_ctrl;
  logic       clk = 1'b0;
  logic       por_n, usr_rst_n, pwrdn_n, prog_n, load_done, done_early;
  logic [2:0] mode_pins;
  logic       cfg_start, obuf_en, core_en, done_drv, store_rst, rb_start;
  logic [2:0] cfg_mode;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  cfgseq_ctrl #(.POR_CYCLES(16)) dut (
    .clk(clk), .por_n(por_n), .usr_rst_n(usr_rst_n), .pwrdn_n(pwrdn_n),
    .mode_pins(mode_pins), .prog_n(prog_n), .load_done(load_done),
    .done_early(done_early), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .obuf_en(obuf_en), .core_en(core_en), .done_drv(done_drv),
    .store_rst(store_rst), .rb_start(rb_start)
  );

  // Output vector {cfg_start, obuf_en, core_en, done_drv, rb_start, store_rst}
  wire [5:0] outv = {cfg_start, obuf_en, core_en, done_drv, rb_start, store_rst};

  // Entry: {req[3:0], pins{usr_rst_n,pwrdn_n,mode0,prog_n,load_done}[4:0], wait[2:0], expected outv[5:0]}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {4'd10, 5'b11010, 3'd3, 6'b011100},  // R10 falling trigger: no pulse
    {4'd10, 5'b11110, 3'd2, 6'b011100},  // R10 not yet
    {4'd10, 5'b11110, 3'd1, 6'b011110},  // R10 pulse at third edge
    {4'd10, 5'b11110, 3'd1, 6'b011100},  // R10 single cycle
    {4'd10, 5'b11010, 3'd3, 6'b011100},  // R10 falling again
    {4'd8,  5'b10010, 3'd3, 6'b000001},  // R8 power-down dark
    {4'd11, 5'b10110, 3'd4, 6'b000001},  // R11 trigger in power-down ignored
    {4'd8,  5'b11110, 3'd3, 6'b010001},  // R8 resume: buffers first
    {4'd8,  5'b11110, 3'd1, 6'b011000},  // R8 activation
    {4'd8,  5'b11110, 3'd1, 6'b011100},  // R8 DONE after (late option)
    {4'd11, 5'b11110, 3'd2, 6'b011100},  // R11 stale trigger level
    {4'd9,  5'b11000, 3'd3, 6'b000001},  // R9 program fall clears
    {4'd9,  5'b11000, 3'd1, 6'b100001},  // R9 restart request
    {4'd9,  5'b11000, 3'd1, 6'b000001},  // R9 request single cycle
    {4'd6,  5'b11001, 3'd1, 6'b010001},  // R6 loader strobe
    {4'd6,  5'b11010, 3'd1, 6'b011000},  // R6 activation
    {4'd6,  5'b11010, 3'd1, 6'b011100}   // R6 DONE late
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    int seen;
    por_n = 0; usr_rst_n = 1; pwrdn_n = 1; mode_pins = 3'b101;
    prog_n = 1; load_done = 0; done_early = 0;
    tick(3);
    chk("R1 reset outputs", outv, 6'b000001);
    chk("R1 reset mode", cfg_mode, 3'b000);

    por_n = 1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      tick(1);
      cnt++;
      if (cfg_start) break;
    end
    chk("R2 timeout latency", cnt, 17);
    chk("R4 mode latched", cfg_mode, 3'b101);
    tick(1);
    chk("R2 start is one cycle", cfg_start, 1'b0);

    prog_n = 0;
    tick(5);
    chk("R11 program edge while configuring", outv, 6'b000001);
    prog_n = 1;
    tick(3);

    load_done = 1; tick(1); load_done = 0;
    chk("R6 phase 0", outv, 6'b010001);
    tick(1);
    chk("R6 phase 1", outv, 6'b011000);
    tick(1);
    chk("R6 operating", outv, 6'b011100);
    tick(2);
    chk("R11 held trigger level", outv, 6'b011100);

    for (int k = 0; k < NV; k++) begin
      {usr_rst_n, pwrdn_n, mode_pins[0], prog_n, load_done} = VEC[k][13:9];
      tick(int'(VEC[k][8:6]));
      chk($sformatf("R%0d vector %0d", VEC[k][17:14], k), outv, VEC[k][5:0]);
    end

    usr_rst_n = 0;
    #1;
    chk("R7 async storage reset", {store_rst, core_en, done_drv, obuf_en}, 4'b1111);
    tick(5);
    chk("R7 no reconfiguration", outv, 6'b011101);
    usr_rst_n = 1;
    #1;
    chk("R7 storage reset released", store_rst, 1'b0);
    tick(4);
    chk("R7 still operating", outv, 6'b011100);

    done_early = 1;
    pwrdn_n = 0;
    tick(2);
    chk("R8 not yet dark", obuf_en, 1'b1);
    tick(1);
    chk("R8 dark", outv, 6'b000001);
    pwrdn_n = 1;
    tick(3);
    chk("R8 resume early DONE", outv, 6'b010101);
    tick(1);
    chk("R8 resume activation", outv, 6'b011100);
    tick(1);
    chk("R8 resumed", outv, 6'b011100);

    por_n = 0; usr_rst_n = 0; mode_pins = 3'b010;
    tick(2);
    por_n = 1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (cfg_start) seen++;
    end
    chk("R3 held reset delays start", seen, 0);
    chk("R3 idle outputs", outv, 6'b000001);
    usr_rst_n = 1;
    tick(2);
    chk("R3 start not early", cfg_start, 1'b0);
    tick(1);
    chk("R3 start on release", cfg_start, 1'b1);
    chk("R4 new mode", cfg_mode, 3'b010);

    usr_rst_n = 0;
    mode_pins = 3'b110;
    tick(3);
    load_done = 1; tick(1); load_done = 0;
    tick(2);
    chk("R5 loader ignored in init", outv, 6'b000001);
    chk("R4 mode held", cfg_mode, 3'b010);
    usr_rst_n = 1;
    tick(2);
    chk("R5 restart not early", cfg_start, 1'b0);
    tick(1);
    chk("R5 restart", cfg_start, 1'b1);
    chk("R5 fresh mode", cfg_mode, 3'b110);
    tick(1);
    load_done = 1; tick(1); load_done = 0;
    chk("R6 early DONE phase 0", outv, 6'b010101);
    tick(1);
    chk("R6 early activation", outv, 6'b011100);
    tick(1);
    chk("R6 early operating", outv, 6'b011100);

    finish_run();
  end
endmodule